// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Load/Store Core

This block is the execute stage of a 32-bit load/store integer core. It receives an instruction word that has already been fetched, together with the two register values the register file read for it. It returns the 32-bit result, the index of the register that result goes to, and a write-enable for the register file. It supports the common three-operand register-register ALU instructions and the register-immediate ALU instructions. This includes shifts by a constant amount, set-on-less-than in signed and unsigned forms, and loading the upper half of a register.

The block finds the format from the 6-bit primary opcode. It extracts the fields, extends the 16-bit immediate by the rule for each instruction, and selects the destination index. For a register-register instruction the destination is the third register field. For a register-immediate instruction it is the second register field. Overflow never traps, so sums and differences wrap. Any encoding outside the supported set is reported as a non-writing slot.

The parameter `REG_OUT` chooses between two variants. With `REG_OUT = 1` a register stage follows the logic and adds one cycle of latency. With `REG_OUT = 0` the outputs follow the inputs in the same cycle.

Top module: `int_exec_unit`

## Requirements
- R1: Bits [31:26] hold the opcode. For opcode 0 (register-register) the destination index is bits [15:11]. For any other supported opcode it is bits [20:16].
- R2: Register-register funct 0x20 and 0x21 produce rs_val + rt_val, and funct 0x22 and 0x23 produce rs_val - rt_val. All four wrap modulo 2^32 and still assert wr_en on overflow.
- R3: Funct 0x24, 0x25 and 0x27 produce the bitwise AND, OR and NOR of rs_val and rt_val. NOR with a zero operand gives the bitwise inverse of the other operand.
- R4: Funct 0x00 shifts rt_val left and funct 0x02 shifts it right, by the amount in bits [10:6]. Both fill the vacated bits with zeros.
- R5: Funct 0x2A and opcode 0x0A compare as two's-complement values. Funct 0x2B and opcode 0x0B compare as unsigned values. The result is 1 when the first operand is less than the second and 0 otherwise.
- R6: Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend the 16-bit immediate in bits [15:0]. Opcodes 0x0C (AND) and 0x0D (OR) zero-extend it. 0x08 and 0x09 both add it to rs_val.
- R7: Opcode 0x0F gives the immediate in bits [31:16] and zeros in bits [15:0]. Loading 0xAAAA this way and then ORing in 0x9999 yields 0xAAAA9999.
- R8: An unsupported opcode, or an unsupported funct under opcode 0, gives wr_en = 0, result = 0 and dest_reg = 0. Every supported encoding gives wr_en = 1.
- R9: With REG_OUT = 1 the outputs show the instruction that was present at the previous rising clock edge. While rst_n is low they are cleared to zero. With REG_OUT = 0 they follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the output register |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| result | output | 32 | Computed result |
| dest_reg | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |

## Verification
The bench builds two copies of the block side by side, one with `REG_OUT = 1` and one with `REG_OUT = 0`, and drives both with the same stimulus. The combinational copy checks every operation in the same cycle. The registered copy checks the one-cycle hold, reset clearing, and the data it shows after the clock. Running the same random and corner operands through both variants exposes latency faults separately from faults in the arithmetic.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned OPC_W   = 6;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLL, ALU_SRL, ALU_SLT, ALU_SLTU, ALU_LUI
  } alu_op_e;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  // function codes under OPC_REG
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  function automatic logic [DATA_W-1:0] f_wrap_add(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [DATA_W-1:0] f_wrap_sub(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x - y;
  endfunction

  function automatic logic f_less_signed(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic f_less_unsigned(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int unsigned D_W  = DATA_W,
  parameter int unsigned RI_W = IDX_W,
  parameter int unsigned SH_W = $clog2(D_W)
) (
  input  logic [31:0]     instr,
  output alu_op_e         alu_op,
  output logic            use_imm,
  output logic [D_W-1:0]  imm_val,
  output logic [SH_W-1:0] shamt,
  output logic [RI_W-1:0] dest,
  output logic            wr_en,
  output logic            illegal,
  output logic            is_cmp
);
  localparam int unsigned OP_LSB = 26;
  localparam int unsigned RS_LSB = 21;
  localparam int unsigned RT_LSB = 16;
  localparam int unsigned RD_LSB = 11;
  localparam int unsigned SA_LSB = 6;

  logic [OPC_W-1:0] opc;
  logic [5:0]       fn;
  logic [RI_W-1:0]  rt_f, rd_f;
  logic [IMM_W-1:0] imm_f;
  logic             unused_rs;

  assign opc       = instr[OP_LSB +: OPC_W];
  assign fn        = instr[5:0];
  assign rt_f      = instr[RT_LSB +: RI_W];
  assign rd_f      = instr[RD_LSB +: RI_W];
  assign imm_f     = instr[IMM_W-1:0];
  assign shamt     = instr[SA_LSB +: SH_W];
  assign unused_rs = &{1'b0, instr[RS_LSB +: RI_W]};

  always_comb begin
    alu_op  = ALU_NONE;
    use_imm = 1'b0;
    imm_val = f_sext(imm_f);
    dest    = '0;
    wr_en   = 1'b0;
    illegal = 1'b1;
    is_cmp  = 1'b0;
    if (opc == OPC_REG) begin
      illegal = 1'b0;
      unique case (fn)
        FN_ADD, FN_ADDU: alu_op = ALU_ADD;
        FN_SUB, FN_SUBU: alu_op = ALU_SUB;
        FN_AND:          alu_op = ALU_AND;
        FN_OR:           alu_op = ALU_OR;
        FN_NOR:          alu_op = ALU_NOR;
        FN_SLL:          alu_op = ALU_SLL;
        FN_SRL:          alu_op = ALU_SRL;
        FN_SLT:          alu_op = ALU_SLT;
        FN_SLTU:         alu_op = ALU_SLTU;
        default:         illegal = 1'b1;
      endcase
      if (!illegal) begin
        dest  = rd_f;
        wr_en = 1'b1;
      end
    end else begin
      illegal = 1'b0;
      use_imm = 1'b1;
      unique case (opc)
        OPC_ADDI, OPC_ADDIU: alu_op = ALU_ADD;
        OPC_SLTI:            alu_op = ALU_SLT;
        OPC_SLTIU:           alu_op = ALU_SLTU;
        OPC_ANDI: begin alu_op = ALU_AND; imm_val = f_zext(imm_f); end
        OPC_ORI:  begin alu_op = ALU_OR;  imm_val = f_zext(imm_f); end
        OPC_LUI:  begin alu_op = ALU_LUI; imm_val = f_zext(imm_f); end
        default:  begin illegal = 1'b1; use_imm = 1'b0; end
      endcase
      if (!illegal) begin
        dest  = rt_f;
        wr_en = 1'b1;
      end
    end
    is_cmp = (alu_op == ALU_SLT) || (alu_op == ALU_SLTU);
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int unsigned D_W  = DATA_W,
  parameter int unsigned SH_W = $clog2(D_W)
) (
  input  alu_op_e         alu_op,
  input  logic [D_W-1:0]  opa,
  input  logic [D_W-1:0]  opb,
  input  logic [SH_W-1:0] shamt,
  output logic [D_W-1:0]  res
);
  always_comb begin
    unique case (alu_op)
      ALU_ADD:  res = f_wrap_add(opa, opb);
      ALU_SUB:  res = f_wrap_sub(opa, opb);
      ALU_AND:  res = opa & opb;
      ALU_OR:   res = opa | opb;
      ALU_NOR:  res = ~(opa | opb);
      ALU_SLL:  res = opb << shamt;
      ALU_SRL:  res = opb >> shamt;
      ALU_SLT:  res = {{(D_W-1){1'b0}}, f_less_signed(opa, opb)};
      ALU_SLTU: res = {{(D_W-1){1'b0}}, f_less_unsigned(opa, opb)};
      ALU_LUI:  res = opb << IMM_W;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/exec_out_stage.sv
module exec_out_stage #(
  parameter int unsigned D_W        = 32,
  parameter int unsigned RI_W       = 5,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [D_W-1:0]  d_res,
  input  logic [RI_W-1:0] d_dest,
  input  logic            d_we,
  output logic [D_W-1:0]  q_res,
  output logic [RI_W-1:0] q_dest,
  output logic            q_we
);
  generate
    if (REGISTERED) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_res  <= '0;
          q_dest <= '0;
          q_we   <= 1'b0;
        end else begin
          q_res  <= d_res;
          q_dest <= d_dest;
          q_we   <= d_we;
        end
      end
    end else begin : g_wire
      logic unused_clk;
      assign unused_clk = &{1'b0, clk, rst_n};
      assign q_res  = d_res;
      assign q_dest = d_dest;
      assign q_we   = d_we;
    end
  endgenerate
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int unsigned D_W     = DATA_W,
  parameter int unsigned RI_W    = IDX_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic [D_W-1:0]  rs_val,
  input  logic [D_W-1:0]  rt_val,
  output logic [D_W-1:0]  result,
  output logic [RI_W-1:0] dest_reg,
  output logic            wr_en
);
  localparam int unsigned SH_W = $clog2(D_W);

  alu_op_e         dec_op;
  logic            dec_use_imm;
  logic [D_W-1:0]  dec_imm;
  logic [SH_W-1:0] dec_shamt;
  logic [RI_W-1:0] dec_dest;
  logic            dec_we;
  logic            dec_illegal;
  logic            dec_is_cmp;
  logic [D_W-1:0]  alu_b;
  logic [D_W-1:0]  alu_res;

  exec_decode #(.D_W(D_W), .RI_W(RI_W), .SH_W(SH_W)) u_dec (
    .instr   (instr),
    .alu_op  (dec_op),
    .use_imm (dec_use_imm),
    .imm_val (dec_imm),
    .shamt   (dec_shamt),
    .dest    (dec_dest),
    .wr_en   (dec_we),
    .illegal (dec_illegal),
    .is_cmp  (dec_is_cmp)
  );

  assign alu_b = dec_use_imm ? dec_imm : rt_val;

  exec_alu #(.D_W(D_W), .SH_W(SH_W)) u_alu (
    .alu_op (dec_op),
    .opa    (rs_val),
    .opb    (alu_b),
    .shamt  (dec_shamt),
    .res    (alu_res)
  );

  exec_out_stage #(.D_W(D_W), .RI_W(RI_W), .REGISTERED(REG_OUT)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_res  (alu_res),
    .d_dest (dec_dest),
    .d_we   (dec_we),
    .q_res  (result),
    .q_dest (dest_reg),
    .q_we   (wr_en)
  );
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr,
  input logic [31:0] result,
  input logic [4:0]  dest_reg,
  input logic        wr_en,
  input logic        illegal,
  input logic        is_cmp
);
  logic [31:0] ins_v;
  logic        ill_v, cmp_v, seen;

  generate
    if (REG_OUT) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ins_v <= '0; ill_v <= 1'b0; cmp_v <= 1'b0; seen <= 1'b0;
        end else begin
          ins_v <= instr; ill_v <= illegal; cmp_v <= is_cmp; seen <= 1'b1;
        end
      end
    end else begin : g_same
      assign ins_v = instr;
      assign ill_v = illegal;
      assign cmp_v = is_cmp;
      assign seen  = rst_n;
    end
  endgenerate

  assert_dest_regform_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && wr_en && ins_v[31:26] == 6'h00) |-> dest_reg == ins_v[15:11]);
  assert_dest_immform_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && wr_en && ins_v[31:26] != 6'h00) |-> dest_reg == ins_v[20:16]);
  assert_srl_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ins_v[31:26] == 6'h00 && ins_v[5:0] == 6'h02)
      |-> (result & ~(32'hFFFF_FFFF >> ins_v[10:6])) == 32'h0);
  assert_compare_boolean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cmp_v) |-> result[31:1] == 31'h0);
  assert_upper_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ins_v[31:26] == 6'h0F) |-> result == {ins_v[15:0], 16'h0000});
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ill_v) |-> (!wr_en && result == 32'h0 && dest_reg == 5'h0));
  assert_legal_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ill_v) |-> wr_en);
endmodule

bind int_exec_unit exec_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .instr    (instr),
  .result   (result),
  .dest_reg (dest_reg),
  .wr_en    (wr_en),
  .illegal  (dec_illegal),
  .is_cmp   (dec_is_cmp)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] r_res, c_res;
  logic [4:0]  r_dest, c_dest;
  logic        r_we, c_we;
  int          n_checks = 0, n_fail = 0;
  bit          finished = 0;
  logic [31:0] pr; logic [4:0] pd; logic pw;

  always #10 clk = ~clk;

  int_exec_unit #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(r_res), .dest_reg(r_dest), .wr_en(r_we));
  int_exec_unit #(.REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(c_res), .dest_reg(c_dest), .wr_en(c_we));

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs, rt, rd, sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // reference model written from the requirements
  function automatic void model(input logic [31:0] ins, a, b,
                                output logic [31:0] r, output logic [4:0] d,
                                output logic w, output string tg);
    logic [15:0] im = ins[15:0];
    logic [31:0] se = {{16{im[15]}}, im};
    logic [31:0] ze = {16'h0, im};
    w = 1'b1; r = '0; d = '0; tg = "R8";
    if (ins[31:26] == 6'h00) begin
      d = ins[15:11];
      case (ins[5:0])
        6'h20, 6'h21: begin r = a + b; tg = "R2"; end
        6'h22, 6'h23: begin r = a - b; tg = "R2"; end
        6'h24: begin r = a & b; tg = "R3"; end
        6'h25: begin r = a | b; tg = "R3"; end
        6'h27: begin r = ~(a | b); tg = "R3"; end
        6'h00: begin r = b << ins[10:6]; tg = "R4"; end
        6'h02: begin r = b >> ins[10:6]; tg = "R4"; end
        6'h2A: begin r = {31'h0, $signed(a) < $signed(b)}; tg = "R5"; end
        6'h2B: begin r = {31'h0, a < b}; tg = "R5"; end
        default: begin w = 1'b0; d = '0; end
      endcase
    end else begin
      d = ins[20:16];
      case (ins[31:26])
        6'h08, 6'h09: begin r = a + se; tg = "R6"; end
        6'h0A: begin r = {31'h0, $signed(a) < $signed(se)}; tg = "R5"; end
        6'h0B: begin r = {31'h0, a < se}; tg = "R5"; end
        6'h0C: begin r = a & ze; tg = "R6"; end
        6'h0D: begin r = a | ze; tg = "R6"; end
        6'h0F: begin r = {im, 16'h0}; tg = "R7"; end
        default: begin w = 1'b0; d = '0; end
      endcase
    end
  endfunction

  task automatic chk(input string tg, input string what, input logic [37:0] got, input logic [37:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tg, what, got, exp);
    end
  endtask

  task automatic check_outs(input string tg, input string who, input logic [31:0] gr, input logic [4:0] gd,
                            input logic gw, input logic [31:0] er, input logic [4:0] ed, input logic ew);
    chk(tg, {who, " result"}, {6'h0, gr}, {6'h0, er});
    chk(ew ? "R1" : "R8", {who, " dest/we"}, {32'h0, gw, gd}, {32'h0, ew, ed});
  endtask

  task automatic apply(input logic [31:0] ins, a, b);
    logic [31:0] er; logic [4:0] ed; logic ew; string tg;
    model(ins, a, b, er, ed, ew, tg);
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b;
    #2;
    check_outs(tg, "comb", c_res, c_dest, c_we, er, ed, ew);
    chk("R9", "reg hold", {r_we, r_dest, r_res}, {pw, pd, pr});
    @(negedge clk);
    check_outs(tg, "reg", r_res, r_dest, r_we, er, ed, ew);
    pr = er; pd = ed; pw = ew;
  endtask

  function automatic logic [31:0] pick_val();
    logic [31:0] corner [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    if ($urandom_range(0, 3) == 0) return corner[$urandom_range(0, 4)];
    return $urandom();
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [5:0] rfn [11] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h27, 6'h00, 6'h02, 6'h2A, 6'h2B};
    logic [5:0] iop [7]  = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0F};
    logic [5:0] bad_op [4] = '{6'h23, 6'h2B, 6'h04, 6'h02};
    logic [5:0] bad_fn [4] = '{6'h26, 6'h08, 6'h03, 6'h18};
    logic [31:0] hi;
    void'($urandom(32'h5EED_1234));
    // reset state (R9)
    repeat (3) @(negedge clk);
    chk("R9", "reset state", {r_we, r_dest, r_res}, 38'h0);
    rst_n = 1'b1;
    pr = '0; pd = '0; pw = 1'b1;   // sll r0 of zero captured at first edge

    // directed corners
    apply(enc_r(6'h20, 5'd1, 5'd2, 5'd3, 5'd0), 32'h7FFF_FFFF, 32'h1);        // R2 wrap
    apply(enc_r(6'h23, 5'd1, 5'd2, 5'd31, 5'd0), 32'h0, 32'h1);               // R2 borrow
    apply(enc_r(6'h27, 5'd0, 5'd9, 5'd10, 5'd0), 32'h0, 32'h1234_5678);       // R3 NOT via nor
    apply(enc_r(6'h00, 5'd0, 5'd4, 5'd5, 5'd31), 32'h0, 32'h0000_0003);       // R4 sll 31
    apply(enc_r(6'h02, 5'd0, 5'd4, 5'd5, 5'd31), 32'h0, 32'h8000_0000);       // R4 srl 31
    apply(enc_r(6'h2A, 5'd6, 5'd7, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'h1);        // R5 signed -> 1
    apply(enc_r(6'h2B, 5'd6, 5'd7, 5'd8, 5'd0), 32'hFFFF_FFFF, 32'h1);        // R5 unsigned -> 0
    apply(enc_i(6'h0B, 5'd6, 5'd7, 16'hFFFF), 32'h7000_0000, 32'h0);          // R5/R6 sltiu sext
    apply(enc_i(6'h08, 5'd2, 5'd12, 16'hFFFF), 32'h0000_0010, 32'h0);         // R6 addi -1
    apply(enc_i(6'h0C, 5'd2, 5'd12, 16'hFFFF), 32'hDEAD_BEEF, 32'h0);         // R6 andi zext
    apply(enc_r(6'h26, 5'd1, 5'd2, 5'd3, 5'd0), 32'h5, 32'h6);                // R8 bad funct
    apply(enc_i(6'h23, 5'd1, 5'd2, 16'h0040), 32'h5, 32'h6);                  // R8 bad opcode
    // R7 upper-load then OR chain through the port
    apply(enc_i(6'h0F, 5'd0, 5'd8, 16'hAAAA), 32'h0, 32'h0);
    hi = r_res;
    apply(enc_i(6'h0D, 5'd8, 5'd8, 16'h9999), hi, 32'h0);
    chk("R7", "lui+ori chain", {6'h0, r_res}, {6'h0, 32'hAAAA_9999});

    // constrained random
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 19);
      logic [4:0] f1 = 5'($urandom()), f2 = 5'($urandom()), f3 = 5'($urandom()), f4 = 5'($urandom());
      logic [31:0] ins;
      if (k < 11)      ins = enc_r(rfn[k], f1, f2, f3, f4);
      else if (k < 18) ins = enc_i(iop[k-11], f1, f2, 16'($urandom()));
      else if (k == 18) ins = enc_i(bad_op[$urandom_range(0, 3)], f1, f2, 16'($urandom()));
      else             ins = enc_r(bad_fn[$urandom_range(0, 3)], f1, f2, f3, f4);
      apply(ins, pick_val(), pick_val());
    end

    // reset in mid-run clears the register stage (R9)
    @(negedge clk); rst_n = 1'b0; #2;
    chk("R9", "mid-run reset", {r_we, r_dest, r_res}, 38'h0);
    finished = 1;
    summary();
    $finish;
  end
endmodule